// File: doc/BRIEF.md
# FIR Host Register Block and Coefficient Loader

This block is the host-facing side of a multiply-accumulate filter engine. It is an 8-bit bus slave with a 2-bit address. After reset it decodes the bus in a data-strobe style, where a strobe qualifies the access and a separate read/write line picks the direction. Software can switch it to a separate-write and separate-read style, and then lock that choice. The block holds the run control, the output normalization setting and the filter length. It presents these to the engine as plain register outputs.

Coefficients reach the engine through one byte-wide port. Each pair of bytes is joined into a 16-bit word, most significant byte first or last as software chooses. The word is then written into the engine's coefficient memory at consecutive addresses. Read-only status bits follow the loading progress, so software can tell when it has reached the last group of four taps and the last tap itself.

The bus pins are asynchronous to the system clock. The strobe lines pass through a two-stage synchronizer. A small state machine then takes each write into the clock domain. ST_IDLE moves to ST_WR_HELD when it sees a qualified write, and captures the address and data at that moment. ST_WR_HELD moves to ST_COMMIT when the strobe is released. ST_COMMIT applies the write for exactly one cycle and always returns to ST_IDLE. Reads do not pass through the state machine: the data bus is driven combinationally while chip select and read are both active.

Top module: `fir_host_regs`

## Requirements
- R1: Reset state. Configuration reads 0xC4, with byte-order = 1 and both last-flags = 1. Normalization reads 0. Order reads 0. The outputs are all inactive, and `coef_we` is low.
- R2: Bus style bit 1 = 0 (the reset value): a write is chip select low, strobe low and `bus_rw_n` low, and a read is chip select low, strobe low and `bus_rw_n` high. Bus style bit 1 = 1: `bus_stb_n` is an active-low write and `bus_rw_n` is an active-low read. Holding `bus_rw_n` low with the strobe high writes nothing in the data-strobe style.
- R3: Address 1 is the configuration register, with run at bit 0, bus style at bit 1, byte order at bit 2 and lock at bit 3. The bus-style bit changes only when a write arrives while lock is 0. Lock is cleared by reset or by writing 0 to bit 3.
- R4: While lock is 0, writes to addresses 0, 2 and 3 are ignored.
- R5: Configuration bits 7:4 are read-only. Bit 4 = sequential mode, bit 5 = the `smp_buf_full` input, bit 6 = last sub-filter, bit 7 = last coefficient. Writes to these bits have no effect.
- R6: Address 2 holds the window select in bits 3:0 and round enable in bit 4. Bits 7:5 read 0.
- R7: Address 3 holds the tap count minus 1. Sequential mode (`seq_mode` and configuration bit 4) is 1 exactly when this value is greater than 3.
- R8: At address 0, the first byte is held and the second byte completes a 16-bit word. With byte order = 1 the first byte is the upper half; with byte order = 0 it is the lower half. On completion, `coef_we` pulses for one cycle with the word at the current load address. Load addresses start at 0 and increment by 1.
- R9: Writing address 3 returns the load address to 0 and discards any half-assembled byte.
- R10: The last-coefficient flag is 1 when the load address equals the order value. The last-sub-filter flag is 1 when the two agree in all bits above bit 1. After the word at the order address, the load address wraps to 0.
- R11: `bus_doe` is high only while chip select and read are both active. Reads of address 0 return 0.
- R12: `run_en`, `norm_sel`, `round_en` and `tap_last` follow the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data |
| bus_doe | output | 1 | Drive enable for the host data bus |
| bus_addr | input | 2 | Register address |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_stb_n | input | 1 | Data strobe or write, active low |
| bus_rw_n | input | 1 | Read/write direction or read, active low |
| smp_buf_full | input | 1 | Engine's sample-buffer-full indication |
| coef_we | output | 1 | Coefficient memory write pulse |
| coef_waddr | output | 8 | Coefficient memory address |
| coef_wdata | output | 16 | Coefficient word |
| run_en | output | 1 | Filtering enabled |
| norm_sel | output | 4 | Output window select |
| round_en | output | 1 | Rounding enable |
| tap_last | output | 8 | Tap count minus 1 |
| seq_mode | output | 1 | Sequential (multiplexed) operation |

## Verification
The bench goes after four corner cases:
- **Locked style bit.** It tries to flip the bus-style bit while locked. A design that ignored the lock would lose the bus, and every later read in the expected style would fail.
- **Half-assembled coefficient.** It leaves a single coefficient byte pending and then rewrites the order. A design that kept the stale byte would pair it with the next byte, and the word and its address would both be wrong.
- **Status at the edges of the load.** It loads past the last-sub-filter boundary and through the wrap of the load address. An off-by-one counter or flag shows up in the status reads and in the memory address.
- **Ignored writes.** It sends writes while unlocked, plus a direction-only pulse with the strobe high. If any of these took effect, the register outputs or an unexpected memory write would reveal it.

// File: rtl/fir_host_pkg.sv
package fir_host_pkg;

    localparam int HB_DW = 8;
    localparam int HB_AW = 2;

    // register map: address 0 is the coefficient port
    localparam logic [HB_AW-1:0] RA_COEF  = 2'd0;
    localparam logic [HB_AW-1:0] RA_CFG   = 2'd1;
    localparam logic [HB_AW-1:0] RA_NORM  = 2'd2;
    localparam logic [HB_AW-1:0] RA_ORDER = 2'd3;

    // configuration register bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_STYLE = 1;
    localparam int CB_MSB   = 2;
    localparam int CB_LOCK  = 3;

    localparam int NORM_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HELD = 2'd1,
        ST_COMMIT  = 2'd2
    } hb_state_t;

endpackage

// File: rtl/fhl_sync.sv
module fhl_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= INIT;
        else        chain[0] <= d;
    end

    generate
        for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[gi] <= INIT;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fhl_bus_fsm.sv
module fhl_bus_fsm
    import fir_host_pkg::*;
#(
    parameter int DW = HB_DW,
    parameter int AW = HB_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          stb_s,
    input  logic          rw_s,
    input  logic          style,
    input  logic [AW-1:0] addr_pin,
    input  logic [DW-1:0] din_pin,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    hb_state_t     state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          wr_seen;

    // style 1: strobe is the write line; style 0: strobe plus low direction
    assign wr_seen = !cs_s && !stb_s && (style || !rw_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_IDLE && wr_seen) begin
            addr_q <= addr_pin;
            data_q <= din_pin;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_seen)  state_d = ST_WR_HELD;
            ST_WR_HELD: if (!wr_seen) state_d = ST_COMMIT;
            ST_COMMIT:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_go   = (state_q == ST_COMMIT);
        wr_addr = addr_q;
        wr_data = data_q;
    end

    // R2: a write is applied only after the strobe has been seen held
    a_r2_commit_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_WR_HELD));
endmodule

// File: rtl/fhl_regs.sv
module fhl_regs
    import fir_host_pkg::*;
#(
    parameter int DW = HB_DW,
    parameter int AW = HB_AW,
    localparam int CW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic              buf_full,
    output logic [DW-1:0]     rd_data,
    output logic              style,
    output logic              coef_we,
    output logic [DW-1:0]     coef_waddr,
    output logic [CW-1:0]     coef_wdata,
    output logic              run_en,
    output logic [NORM_W-2:0] norm_sel,
    output logic              round_en,
    output logic [DW-1:0]     tap_last,
    output logic              seq_mode
);
    logic              run_q, style_q, msb_q, lock_q;
    logic [NORM_W-1:0] norm_q;
    logic [DW-1:0]     order_q, cnt_q, hold_q;
    logic              phase_q;
    logic              last_coef, last_sub;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            style_q    <= 1'b0;
            msb_q      <= 1'b1;
            lock_q     <= 1'b0;
            norm_q     <= '0;
            order_q    <= '0;
            cnt_q      <= '0;
            hold_q     <= '0;
            phase_q    <= 1'b0;
            coef_we    <= 1'b0;
            coef_waddr <= '0;
            coef_wdata <= '0;
        end else begin
            coef_we <= 1'b0;
            if (wr_go) begin
                unique case (wr_addr)
                    RA_CFG: begin
                        run_q  <= wr_data[CB_RUN];
                        msb_q  <= wr_data[CB_MSB];
                        lock_q <= wr_data[CB_LOCK];
                        if (!lock_q) style_q <= wr_data[CB_STYLE];
                    end
                    RA_NORM: if (lock_q) norm_q <= wr_data[NORM_W-1:0];
                    RA_ORDER: if (lock_q) begin
                        order_q <= wr_data;
                        cnt_q   <= '0;
                        phase_q <= 1'b0;
                    end
                    RA_COEF: if (lock_q) begin
                        if (!phase_q) begin
                            hold_q  <= wr_data;
                            phase_q <= 1'b1;
                        end else begin
                            phase_q    <= 1'b0;
                            coef_we    <= 1'b1;
                            coef_waddr <= cnt_q;
                            coef_wdata <= msb_q ? {hold_q, wr_data} : {wr_data, hold_q};
                            cnt_q      <= last_coef ? '0 : cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        last_coef = (cnt_q == order_q);
        last_sub  = (cnt_q[DW-1:2] == order_q[DW-1:2]);
        seq_mode  = |order_q[DW-1:2];
        run_en    = run_q;
        style     = style_q;
        norm_sel  = norm_q[NORM_W-2:0];
        round_en  = norm_q[NORM_W-1];
        tap_last  = order_q;
        unique case (rd_addr)
            RA_CFG:   rd_data = {last_coef, last_sub, buf_full, seq_mode,
                                 lock_q, msb_q, style_q, run_q};
            RA_NORM:  rd_data = {{(DW-NORM_W){1'b0}}, norm_q};
            RA_ORDER: rd_data = order_q;
            default:  rd_data = '0;
        endcase
    end

    // R3: bus style frozen while locked
    a_r3_style_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(style_q));
    // R8: one write pulse per completed word
    a_r8_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |=> !coef_we);
    // R9: order write rewinds the loader
    a_r9_order_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_addr == RA_ORDER && lock_q) |=> (cnt_q == '0 && !phase_q));
    // R4: no coefficient traffic while unlocked
    a_r4_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !coef_we);
endmodule

// File: rtl/fir_host_regs.sv
module fir_host_regs
    import fir_host_pkg::*;
#(
    parameter int DW = HB_DW,
    parameter int AW = HB_AW,
    parameter int SYNC_STAGES = 2,
    localparam int CW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     bus_din,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_cs_n,
    input  logic              bus_stb_n,
    input  logic              bus_rw_n,
    input  logic              smp_buf_full,
    output logic              coef_we,
    output logic [DW-1:0]     coef_waddr,
    output logic [CW-1:0]     coef_wdata,
    output logic              run_en,
    output logic [NORM_W-2:0] norm_sel,
    output logic              round_en,
    output logic [DW-1:0]     tap_last,
    output logic              seq_mode
);
    logic [2:0]    ctl_s;
    logic          style, wr_go, rd_act;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data, rd_data;

    fhl_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_cs_n, bus_stb_n, bus_rw_n}), .q(ctl_s)
    );

    fhl_bus_fsm #(.DW(DW), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_s(ctl_s[2]), .stb_s(ctl_s[1]), .rw_s(ctl_s[0]), .style(style),
        .addr_pin(bus_addr), .din_pin(bus_din),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fhl_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(bus_addr), .buf_full(smp_buf_full), .rd_data(rd_data),
        .style(style),
        .coef_we(coef_we), .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
        .run_en(run_en), .norm_sel(norm_sel), .round_en(round_en),
        .tap_last(tap_last), .seq_mode(seq_mode)
    );

    always_comb begin
        rd_act   = !bus_cs_n && (style ? !bus_rw_n : (!bus_stb_n && bus_rw_n));
        bus_doe  = rd_act;
        bus_dout = rd_act ? rd_data : '0;
    end

    // R11: never drive the bus without chip select
    a_r11_drive_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_cs_n);
endmodule

// File: tb/tb_fir_host_regs.sv
module tb_fir_host_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [1:0]  bus_addr = '0;
    logic        bus_cs_n = 1'b1, bus_stb_n = 1'b1, bus_rw_n = 1'b1;
    logic        smp_buf_full = 1'b0;
    logic        coef_we;
    logic [7:0]  coef_waddr;
    logic [15:0] coef_wdata;
    logic        run_en, round_en, seq_mode;
    logic [3:0]  norm_sel;
    logic [7:0]  tap_last;

    fir_host_regs dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit quiet = 0, done = 0;

    // behavioural model
    int m_run = 0, m_style = 0, m_msb = 1, m_lock = 0, m_norm = 0;
    int m_order = 0, m_cnt = 0, m_phase = 0, m_hold = 0;
    logic [23:0] exp_q[$];

    function automatic logic [7:0] cfg_exp();
        logic [7:0] v;
        v[0] = m_run[0]; v[1] = m_style[0]; v[2] = m_msb[0]; v[3] = m_lock[0];
        v[4] = (m_order > 3);
        v[5] = smp_buf_full;
        v[6] = ((m_cnt / 4) == (m_order / 4));
        v[7] = (m_cnt == m_order);
        return v;
    endfunction

    function automatic logic [7:0] reg_exp(int a);
        case (a)
            1: return cfg_exp();
            2: return 8'(m_norm);
            3: return 8'(m_order);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(int a, int d);
        case (a)
            1: begin
                if (m_lock == 0) m_style = (d >> 1) & 1;
                m_run = d & 1; m_msb = (d >> 2) & 1; m_lock = (d >> 3) & 1;
            end
            2: if (m_lock) m_norm = d & 31;
            3: if (m_lock) begin m_order = d; m_cnt = 0; m_phase = 0; end
            default: if (m_lock) begin
                if (m_phase == 0) begin m_hold = d; m_phase = 1; end
                else begin
                    int w;
                    w = m_msb ? (m_hold * 256 + d) : (d * 256 + m_hold);
                    exp_q.push_back({8'(m_cnt), 16'(w)});
                    m_phase = 0;
                    m_cnt = (m_cnt == m_order) ? 0 : m_cnt + 1;
                end
            end
        endcase
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic hwrite(int a, int d);
        int sty;
        sty = m_style;
        quiet = 0;
        model_write(a, d);
        @(posedge clk); #1;
        bus_addr = 2'(a); bus_din = 8'(d); bus_cs_n = 0;
        if (sty == 0) bus_rw_n = 0;
        bus_stb_n = 0;
        repeat (5) @(posedge clk);
        #1; bus_stb_n = 1; bus_rw_n = 1; bus_cs_n = 1;
        repeat (8) @(posedge clk);
        quiet = 1;
    endtask

    task automatic hread(int a, string tag);
        logic [7:0] e;
        e = reg_exp(a);
        @(posedge clk); #1;
        bus_addr = 2'(a); bus_cs_n = 0;
        if (m_style == 0) begin bus_rw_n = 1; bus_stb_n = 0; end
        else bus_rw_n = 0;
        #2;
        check(bus_doe === 1'b1, {tag, " R11 doe"}, int'(bus_doe), 1);
        check(bus_dout === e, tag, int'(bus_dout), int'(e));
        bus_cs_n = 1; bus_stb_n = 1; bus_rw_n = 1;
        #1;
        check(bus_doe === 1'b0, {tag, " R11 release"}, int'(bus_doe), 0);
    endtask

    // per-clock comparison of the register outputs and the memory port (R12, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (coef_we) begin
                if (exp_q.size() == 0)
                    check(0, "R8 unexpected coef_we", int'({coef_waddr, coef_wdata}), 0);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check({coef_waddr, coef_wdata} === e, "R8 R10 coef word",
                          int'({coef_waddr, coef_wdata}), int'(e));
                end
            end
            if (quiet) begin
                logic [17:0] a, e;
                a = {run_en, norm_sel, round_en, tap_last, seq_mode, coef_we, 2'b00};
                e = {m_run[0], 4'(m_norm), m_norm[4], 8'(m_order), (m_order > 3), 1'b0, 2'b00};
                check(a === e, "R12 R7 outputs", int'(a), int'(e));
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        repeat (2) @(posedge clk);
        quiet = 1;
        // R1 reset values
        @(posedge clk); #1;
        bus_addr = 2'd1; bus_cs_n = 0; bus_stb_n = 0; #2;
        check(bus_dout === 8'hC4, "R1 cfg reset", int'(bus_dout), 'hC4);
        bus_cs_n = 1; bus_stb_n = 1;
        hread(2, "R1 norm reset");
        hread(3, "R1 order reset");
        hread(0, "R11 coef addr reads 0");
        // R4 unlocked writes ignored
        hwrite(3, 5);
        hwrite(2, 8'h13);
        hread(3, "R4 order unlocked");
        // R3 choose strobe style 1 and lock, LSB first
        hwrite(1, 8'h0A);
        hread(1, "R2 R3 style1 locked");
        hwrite(1, 8'h0C);
        hread(1, "R3 style frozen");
        // R5 read-only status
        hwrite(1, 8'hFE);
        hread(1, "R5 status ignores writes");
        smp_buf_full = 1;
        hread(1, "R5 buffer full bit");
        smp_buf_full = 0;
        // R6 normalization
        hwrite(2, 8'hFF);
        hread(2, "R6 norm 5 bits");
        // R7 order and sequential mode
        hwrite(3, 5);
        hread(3, "R7 order");
        hread(1, "R7 seq flag");
        // R8 R10 MSB-first load through wrap
        for (int i = 0; i < 6; i++) begin
            int w;
            w = (16'h1357 * (i + 1)) & 16'hFFFF;
            hwrite(0, w >> 8);
            hwrite(0, w & 255);
            hread(1, "R10 last flags");
        end
        // R8 R9 LSB-first with stale half byte
        hwrite(1, 8'h0B);
        hwrite(0, 8'h77);
        hwrite(3, 2);
        hwrite(0, 8'h34);
        hwrite(0, 8'h12);
        hread(1, "R9 R10 after rewind");
        // unlock, ignored writes, switch to style 0
        hwrite(1, 8'h02);
        hwrite(3, 7);
        hwrite(0, 8'h55);
        hwrite(0, 8'h66);
        hread(3, "R4 order while unlocked");
        hwrite(1, 8'h08);
        hread(1, "R2 R3 style0 relocked");
        // R2 direction without strobe is no write
        @(posedge clk); #1;
        bus_addr = 2'd3; bus_din = 8'd9; bus_cs_n = 0; bus_rw_n = 0;
        repeat (6) @(posedge clk);
        #1; bus_cs_n = 1; bus_rw_n = 1;
        repeat (6) @(posedge clk);
        hread(3, "R2 no strobe no write");
        hwrite(3, 1);
        hread(3, "R2 style0 write");
        hread(1, "R10 flags order1");
        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R8 pending words", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule